// File: doc/BRIEF.md
# Floating-Point Control Attach at Rename

This unit sits in the rename stage of an out-of-order core and owns the architectural floating-point control bits: a rounding mode, a flush-to-zero bit and a denormals-are-zero bit. Each FP instruction picks up a snapshot of these bits at rename. The snapshot travels with the instruction, so execution never has to look up a global register. The control bits are kept in a register of their own, apart from any status flags.

A control write is carried out entirely at rename. The new value becomes current at once. The displaced value is pushed into a small undo store and also leaves rename attached to the write. The write is then marked complete and is never issued. When a branch is flushed, the squashed control writes are unwound one per cycle, youngest first, until the register holds its value from before the oldest squashed write. Rename is held off while this happens. The store entry of a write is released when that write commits.

Top module: `fpctl_rename`

## Requirements
- R1: During and directly after reset, the current control value (`cur_ctl`) is 4'b0000, all output lane valids are 0 and every attached value is zero. The field layout is: bits [1:0] rounding mode (00 = nearest), bit 2 flush-to-zero, bit 3 denormals-are-zero.
- R2: An accepted FP instruction that is not a control write leaves rename one cycle later with `o_ctl` equal to `cur_ctl` as it stood in its accept cycle, `o_fp`=1 and `o_issue`=1.
- R3: An accepted control write whose value is ready makes `cur_ctl` equal its operand value from the next cycle on.
- R4: An accepted control write leaves rename one cycle later with `o_ctl` equal to the value it displaced, `o_done`=1 and `o_issue`=0.
- R5: Lanes are accepted as an in-order prefix (lane 0 is oldest). A control write is the only FP instruction accepted in its cycle. An FP instruction younger than an accepted control write, or a control write younger than an accepted FP instruction, is not accepted, and neither is any lane after it. Non-FP lanes beside the write are accepted.
- R6: A control write whose operand ready bit is 0 is not accepted, nor is any younger lane, and `cur_ctl` does not change.
- R7: While 8 control writes are in flight (accepted and not yet committed), no control write is accepted. A commit frees one entry, and the write is accepted the cycle after that.
- R8: A flush of N writes blocks rename in the flush cycle and in the N cycles after it. In each of those N cycles the youngest remaining write is undone, and `cur_ctl` takes that write's saved previous value.
- R9: A non-FP instruction leaves with `o_fp`=0, `o_ctl`=0 and `o_issue`=1. `cur_ctl` changes only through an accepted control write or an unwind step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | LANES | Lane holds an instruction |
| in_fp | input | LANES | Lane is an FP instruction |
| in_cwr | input | LANES | Lane is an FP control write |
| in_rdy | input | LANES | Control-write operand is available |
| in_val | input | LANES*4 | Control-write operand value per lane |
| in_take | output | LANES | Lanes accepted this cycle (prefix) |
| cm_vld | input | 1 | Oldest in-flight control write commits |
| fl_vld | input | 1 | Flush request |
| fl_cnt | input | CNTW | Number of youngest in-flight writes squashed |
| o_vld | output | LANES | Renamed lane valid |
| o_fp | output | LANES | Lane carries control bits |
| o_issue | output | LANES | Lane goes on to an execution unit |
| o_done | output | LANES | Control write completed as a no-op |
| o_ctl | output | LANES*4 | Attached control bits (displaced value for writes) |
| cur_ctl | output | 4 | Current control value |

## Verification
Pairs of FP instructions and pairs of non-FP instructions show whether bits are attached only to FP work and whether the value attached is the current one. Mixed groups put a control write beside a non-FP instruction, ahead of an FP instruction, or behind one. These groups separate a correct prefix acceptance from one that renames two FP instructions in the same cycle as a write. An operand that is not ready, a full undo store with a commit in the same cycle, and flushes of part of the store and of all of it exercise the stall paths and the order of the unwind. A behavioural model compares the acceptance mask, every output lane and the current value on every cycle.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;
  localparam int CTL_W = 4;
  typedef logic [CTL_W-1:0] ctl_t;
  localparam ctl_t CTL_RESET = '0;
  typedef struct packed {
    logic vld;
    logic fp;
    logic issue;
    logic done;
    ctl_t ctl;
  } lane_out_t;
endpackage

// File: rtl/fpctl_pick.sv
module fpctl_pick #(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int CNTW  = 4
) (
  input  logic             busy,
  input  logic [CNTW-1:0]  used,
  input  logic [LANES-1:0] v,
  input  logic [LANES-1:0] fp,
  input  logic [LANES-1:0] cw,
  input  logic [LANES-1:0] rdy,
  output logic [LANES-1:0] take
);
  logic full;
  assign full = (used >= CNTW'(DEPTH));

  // in-order prefix; a control write is the only FP op in its group
  always_comb begin
    logic stop;
    logic fp_seen;
    logic cw_seen;
    take    = '0;
    stop    = busy;
    fp_seen = 1'b0;
    cw_seen = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!stop) begin
        if (!v[i]) begin
          stop = 1'b1;
        end else if (cw[i]) begin
          if (fp_seen || !rdy[i] || full) begin
            stop = 1'b1;
          end else begin
            take[i] = 1'b1;
            fp_seen = 1'b1;
            cw_seen = 1'b1;
          end
        end else if (fp[i]) begin
          if (cw_seen) begin
            stop = 1'b1;
          end else begin
            take[i] = 1'b1;
            fp_seen = 1'b1;
          end
        end else begin
          take[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fpctl_undo_store.sv
module fpctl_undo_store
  import fpctl_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNTW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  ctl_t            push_val,
  input  logic            pop,
  input  logic            release_old,
  output ctl_t            top_val,
  output logic [CNTW-1:0] used
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctl_t          mem [DEPTH];
  logic [PW-1:0] wp;
  logic          pop_ok;
  logic          rel_ok;

  assign pop_ok  = pop && (used != '0);
  assign rel_ok  = release_old && (used != '0) && !(pop_ok && used == CNTW'(1));
  assign top_val = mem[wp - PW'(1)];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      used <= '0;
    end else begin
      if (push)        wp <= wp + PW'(1);
      else if (pop_ok) wp <= wp - PW'(1);
      used <= used + CNTW'(push) - CNTW'(pop_ok) - CNTW'(rel_ok);
    end
  end
endmodule

// File: rtl/fpctl_lane_out.sv
module fpctl_lane_out
  import fpctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      take,
  input  logic      fp,
  input  logic      cw,
  input  ctl_t      cur,
  output lane_out_t q
);
  logic is_fp;
  assign is_fp = fp | cw;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q.vld   <= take;
      q.fp    <= take & is_fp;
      q.issue <= take & ~cw;
      q.done  <= take & cw;
      q.ctl   <= (take && is_fp) ? cur : '0;
    end
  end
endmodule

// File: rtl/fpctl_rename.sv
module fpctl_rename
  import fpctl_pkg::*;
#(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       in_vld,
  input  logic [LANES-1:0]       in_fp,
  input  logic [LANES-1:0]       in_cwr,
  input  logic [LANES-1:0]       in_rdy,
  input  logic [LANES*CTL_W-1:0] in_val,
  output logic [LANES-1:0]       in_take,
  input  logic                   cm_vld,
  input  logic                   fl_vld,
  input  logic [CNTW-1:0]        fl_cnt,
  output logic [LANES-1:0]       o_vld,
  output logic [LANES-1:0]       o_fp,
  output logic [LANES-1:0]       o_issue,
  output logic [LANES-1:0]       o_done,
  output logic [LANES*CTL_W-1:0] o_ctl,
  output logic [CTL_W-1:0]       cur_ctl
);
  ctl_t            cur;
  ctl_t            top_val;
  ctl_t            wval;
  logic            wr;
  logic            busy;
  logic            pop;
  logic [CNTW-1:0] used;
  logic [CNTW-1:0] und_left;

  assign pop     = (und_left != '0);
  assign busy    = fl_vld | pop;
  assign cur_ctl = cur;

  fpctl_pick #(.LANES(LANES), .DEPTH(DEPTH), .CNTW(CNTW)) u_pick (
    .busy (busy),
    .used (used),
    .v    (in_vld),
    .fp   (in_fp),
    .cw   (in_cwr),
    .rdy  (in_rdy),
    .take (in_take)
  );

  always_comb begin
    wr   = 1'b0;
    wval = cur;
    for (int i = 0; i < LANES; i++) begin
      if (in_take[i] && in_cwr[i]) begin
        wr   = 1'b1;
        wval = in_val[i*CTL_W +: CTL_W];
      end
    end
  end

  fpctl_undo_store #(.DEPTH(DEPTH), .CNTW(CNTW)) u_store (
    .clk         (clk),
    .rst         (rst),
    .push        (wr),
    .push_val    (cur),
    .pop         (pop),
    .release_old (cm_vld),
    .top_val     (top_val),
    .used        (used)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= CTL_RESET;
      und_left <= '0;
    end else begin
      if (pop && used != '0) cur <= top_val;
      else if (wr)           cur <= wval;
      und_left <= und_left - CNTW'(pop) + (fl_vld ? fl_cnt : '0);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_out_t q;
    fpctl_lane_out u_out (
      .clk  (clk),
      .rst  (rst),
      .take (in_take[g]),
      .fp   (in_fp[g]),
      .cw   (in_cwr[g]),
      .cur  (cur),
      .q    (q)
    );
    assign o_vld[g]                 = q.vld;
    assign o_fp[g]                  = q.fp;
    assign o_issue[g]               = q.issue;
    assign o_done[g]                = q.done;
    assign o_ctl[g*CTL_W +: CTL_W]  = q.ctl;
  end
endmodule

// File: rtl/fpctl_rename_chk.sv
module fpctl_rename_chk #(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int CNTW  = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [LANES-1:0]     in_take,
  input logic [LANES-1:0]     in_fp,
  input logic [LANES-1:0]     in_cwr,
  input logic [LANES-1:0]     in_rdy,
  input logic [LANES*4-1:0]   in_val,
  input logic [3:0]           cur_ctl,
  input logic                 busy,
  input logic [CNTW-1:0]      used
);
  AST_CWR_ALONE: assert property (@(posedge clk) disable iff (rst)
    (|(in_take & in_cwr)) |-> ($countones(in_take & (in_fp | in_cwr)) == 1)); // R5
  AST_CWR_READY: assert property (@(posedge clk) disable iff (rst)
    (|(in_take & in_cwr)) |-> ((in_take & in_cwr & ~in_rdy) == '0)); // R6
  AST_UNWIND_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    busy |-> (in_take == '0)); // R8
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (used == CNTW'(DEPTH)) |-> ((in_take & in_cwr) == '0)); // R7
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && ((in_take & in_cwr) == '0)) |=> $stable(cur_ctl)); // R9
  AST_CWR_APPLY: assert property (@(posedge clk) disable iff (rst)
    (in_take[0] && in_cwr[0]) |=> (cur_ctl == $past(in_val[3:0]))); // R3
endmodule

bind fpctl_rename fpctl_rename_chk #(.LANES(LANES), .DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_take (in_take),
  .in_fp   (in_fp),
  .in_cwr  (in_cwr),
  .in_rdy  (in_rdy),
  .in_val  (in_val),
  .cur_ctl (cur_ctl),
  .busy    (busy),
  .used    (used)
);

// File: tb/sim_fpctl_rename.sv
module sim_fpctl_rename;
  localparam int L = 2;
  localparam int D = 8;
  localparam int CNTW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst;
  logic [L-1:0] in_vld, in_fp, in_cwr, in_rdy, in_take;
  logic [L*4-1:0] in_val;
  logic         cm_vld, fl_vld;
  logic [CNTW-1:0] fl_cnt;
  logic [L-1:0] o_vld, o_fp, o_issue, o_done;
  logic [L*4-1:0] o_ctl;
  logic [3:0]   cur_ctl;

  fpctl_rename #(.LANES(L), .DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_fp(in_fp), .in_cwr(in_cwr),
    .in_rdy(in_rdy), .in_val(in_val), .in_take(in_take), .cm_vld(cm_vld),
    .fl_vld(fl_vld), .fl_cnt(fl_cnt), .o_vld(o_vld), .o_fp(o_fp),
    .o_issue(o_issue), .o_done(o_done), .o_ctl(o_ctl), .cur_ctl(cur_ctl)
  );

  int checks = 0;
  int errors = 0;
  int m_cur = 0;
  int m_q[$];
  int m_und = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] v, input logic [1:0] fp, input logic [1:0] cw,
                      input logic [1:0] rdy, input logic [3:0] v0, input logic [3:0] v1,
                      input logic cm, input logic fl, input int flc, input string req);
    logic stop, fps, cws;
    logic [1:0] tk;
    int vals[2];
    int e_ctl[2];
    int newcur;
    @(negedge clk);
    in_vld = v; in_fp = fp; in_cwr = cw; in_rdy = rdy; in_val = {v1, v0};
    cm_vld = cm; fl_vld = fl; fl_cnt = CNTW'(flc);
    vals[0] = v0; vals[1] = v1;
    #1;
    stop = fl || (m_und > 0); fps = 0; cws = 0; tk = '0;
    for (int i = 0; i < L; i++) begin
      if (!stop) begin
        if (!v[i]) stop = 1;
        else if (cw[i]) begin
          if (fps || !rdy[i] || m_q.size() >= D) stop = 1;
          else begin tk[i] = 1; fps = 1; cws = 1; end
        end else if (fp[i]) begin
          if (cws) stop = 1; else begin tk[i] = 1; fps = 1; end
        end else tk[i] = 1;
      end
    end
    chk(req, "take", int'(in_take), int'(tk));
    newcur = m_cur;
    for (int i = 0; i < L; i++) e_ctl[i] = (tk[i] && (fp[i] || cw[i])) ? m_cur : 0;
    if (m_und > 0) begin
      m_und--;
      if (m_q.size() > 0) newcur = m_q.pop_back();
    end else begin
      for (int i = 0; i < L; i++)
        if (tk[i] && cw[i]) begin m_q.push_back(m_cur); newcur = vals[i]; end
    end
    if (cm && m_q.size() > 0) void'(m_q.pop_front());
    if (fl) m_und += flc;
    @(posedge clk);
    #1;
    m_cur = newcur;
    for (int i = 0; i < L; i++) begin
      chk("R2", "vld", int'(o_vld[i]), int'(tk[i]));
      chk("R4", "done", int'(o_done[i]), int'(tk[i] & cw[i]));
      chk("R4", "issue", int'(o_issue[i]), int'(tk[i] & ~cw[i]));
      chk("R9", "fp", int'(o_fp[i]), int'(tk[i] & (fp[i] | cw[i])));
      chk(cw[i] ? "R4" : (fp[i] ? "R2" : "R9"), "ctl", int'(o_ctl[i*4 +: 4]), e_ctl[i]);
    end
    chk(req, "cur", int'(cur_ctl), m_cur);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; in_vld = 0; in_fp = 0; in_cwr = 0; in_rdy = 0; in_val = 0;
    cm_vld = 0; fl_vld = 0; fl_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "reset vld", int'(o_vld), 0);
    chk("R1", "reset cur", int'(cur_ctl), 0);
    chk("R1", "reset ctl", int'(o_ctl), 0);
    // attach to FP pairs and non-FP pairs
    step(2'b11, 2'b11, 2'b00, 2'b00, 4'h0, 4'h0, 0, 0, 0, "R2");
    step(2'b11, 2'b00, 2'b00, 2'b00, 4'h0, 4'h0, 0, 0, 0, "R9");
    // write with non-FP beside it
    step(2'b11, 2'b00, 2'b01, 2'b01, 4'b0110, 4'h0, 0, 0, 0, "R3");
    step(2'b11, 2'b11, 2'b00, 2'b00, 4'h0, 4'h0, 0, 0, 0, "R2");
    // write then FP: FP waits
    step(2'b11, 2'b10, 2'b01, 2'b01, 4'b1001, 4'h0, 0, 0, 0, "R5");
    step(2'b01, 2'b01, 2'b00, 2'b00, 4'h0, 4'h0, 0, 0, 0, "R5");
    // FP then write: write waits
    step(2'b11, 2'b01, 2'b10, 2'b10, 4'h0, 4'b0011, 0, 0, 0, "R5");
    step(2'b01, 2'b00, 2'b01, 2'b01, 4'b0011, 4'h0, 0, 0, 0, "R5");
    // operand not ready
    step(2'b11, 2'b10, 2'b01, 2'b00, 4'b1111, 4'h0, 0, 0, 0, "R6");
    step(2'b01, 2'b00, 2'b01, 2'b00, 4'b1111, 4'h0, 0, 0, 0, "R6");
    step(2'b01, 2'b00, 2'b01, 2'b01, 4'b1111, 4'h0, 0, 0, 0, "R6");
    // fill the store
    for (int k = 1; k <= 4; k++)
      step(2'b01, 2'b00, 2'b01, 2'b01, 4'(k), 4'h0, 0, 0, 0, "R7");
    step(2'b01, 2'b00, 2'b01, 2'b01, 4'h5, 4'h0, 0, 0, 0, "R7");
    step(2'b01, 2'b00, 2'b01, 2'b01, 4'h5, 4'h0, 1, 0, 0, "R7");
    step(2'b01, 2'b00, 2'b01, 2'b01, 4'h5, 4'h0, 0, 0, 0, "R7");
    // partial flush, then full flush
    step(2'b11, 2'b11, 2'b00, 2'b00, 4'h0, 4'h0, 0, 1, 3, "R8");
    for (int k = 0; k < 4; k++)
      step(2'b11, 2'b11, 2'b00, 2'b00, 4'h0, 4'h0, 0, 0, 0, "R8");
    step(2'b01, 2'b00, 2'b00, 2'b00, 4'h0, 4'h0, 0, 1, 5, "R8");
    for (int k = 0; k < 6; k++)
      step(2'b11, 2'b01, 2'b00, 2'b00, 4'h0, 4'h0, 0, 0, 0, "R8");
    step(2'b01, 2'b00, 2'b01, 2'b01, 4'b1100, 4'h0, 0, 0, 0, "R3");
    step(2'b11, 2'b11, 2'b00, 2'b00, 4'h0, 4'h0, 1, 0, 0, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule